// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two single-precision IEEE-754 operands and reduces the outcome to one condition bit. A 4-bit condition selects which relations between the operands count as true. The relations are less, equal and unordered. The top bit of the condition chooses between a quiet compare and a signalling compare. On a start strobe, the unit evaluates the condition and records the outcome in its compare-result register. In the same step it updates an invalid-operation flag and pulses done. The core reads the result register directly through the `result` port.

Both operands are always decoded, even for the always-false condition, so that invalid-operation detection still takes place for every compare. Positive and negative zero count as equal. Subnormal values are ordered by their value, and the infinities sit at the two ends of the order.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises, `result`, `invalid` and `done` are 0 until the first compare.
- R2: `done` is 1 for exactly the one cycle that follows a cycle with `start` high, and 0 otherwise.
- R3: `result` loads the condition outcome on the clock edge that samples `start` high, so a read in the `done` cycle returns the new value. It keeps that value until the next start.
- R4: Bits 2:0 of `cond` form a mask over the relations: bit 0 selects unordered, bit 1 selects equal, bit 2 selects less (opa < opb). The result is 1 when any selected relation holds. Mask 000 always gives 0.
- R5: `cond` values 8 to 15 produce the same result bit as `cond` values 0 to 7 with the same low three bits. Bit 3 affects only the invalid flag.
- R6: The operands are unordered when either one is a NaN (exponent all ones, fraction nonzero). Exactly one of less, equal, greater or unordered holds for any operand pair.
- R7: +0 and -0 compare equal, in either order.
- R8: Ordered non-zero operands compare by value, including subnormals and negative values.
- R9: In a signalling compare (`cond[3]`=1), any NaN operand sets `invalid`.
- R10: In a quiet compare (`cond[3]`=0), `invalid` is set only by a signalling NaN, which is a NaN whose fraction MSB is 0.
- R11: `invalid` is replaced on every compare and holds between compares, whatever the inputs do.
- R12: -infinity is less than every finite value, +infinity is greater than every finite value, and two equal infinities compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a compare with the current inputs |
| cond | input | 4 | Condition: bit 3 selects signalling, bits 2:0 are the relation mask |
| opa | input | 32 | First operand, single precision |
| opb | input | 32 | Second operand, single precision |
| result | output | 1 | Compare-result register, readable by the core |
| invalid | output | 1 | Invalid-operation flag of the last compare |
| done | output | 1 | One-cycle pulse when the result is written |

## Verification
Random operand pairs are drawn from classes: random bit patterns, signed zeros, infinities, quiet NaNs, signalling NaNs, subnormals, copies of the other operand, and near neighbours that share an exponent. Zero pairs separate a bitwise equality test from a value equality test. The two NaN kinds, each paired with both condition halves, separate the quiet invalid rule from the signalling one. Neighbouring and negative pairs expose a magnitude compare that ignores the sign. Directed cases cover the always-false mask, the infinity ends of the order and the hold behaviour between compares.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;

  // exactly one member is set for any operand pair
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } relation_t;

  // cond[2:0] bit positions
  localparam int SEL_UN = 0;
  localparam int SEL_EQ = 1;
  localparam int SEL_LT = 2;
  localparam int SEL_SIGNALLING = 3;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int EXP_W  = fcmp_pkg::SP_EXP_W,
  parameter int FRAC_W = fcmp_pkg::SP_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [MAG_W-1:0]  mag,
  output logic              is_nan,
  output logic              is_snan,
  output logic              is_zero
);
  logic exp_ones;
  logic frac_nz;

  always_comb begin
    sign     = word[WORD_W-1];
    mag      = word[MAG_W-1:0];
    exp_ones = &word[MAG_W-1:FRAC_W];
    frac_nz  = |word[FRAC_W-1:0];
    is_nan   = exp_ones & frac_nz;
    is_snan  = is_nan & ~word[FRAC_W-1];
    is_zero  = ~|mag;
  end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate #(
  parameter int MAG_W = fcmp_pkg::SP_EXP_W + fcmp_pkg::SP_FRAC_W
) (
  input  logic               a_sign,
  input  logic [MAG_W-1:0]   a_mag,
  input  logic               a_nan,
  input  logic               a_zero,
  input  logic               b_sign,
  input  logic [MAG_W-1:0]   b_mag,
  input  logic               b_nan,
  input  logic               b_zero,
  output fcmp_pkg::relation_t rel
);
  import fcmp_pkg::*;

  function automatic relation_t order_pair(
    input logic sa, input logic [MAG_W-1:0] ma, input logic na, input logic za,
    input logic sb, input logic [MAG_W-1:0] mb, input logic nb, input logic zb);
    relation_t r;
    logic a_below;
    r = '0;
    if (na || nb) begin
      r.un = 1'b1;
    end else if ((za && zb) || (sa == sb && ma == mb)) begin
      r.eq = 1'b1;
    end else begin
      if (sa != sb) a_below = sa;
      else          a_below = sa ? (ma > mb) : (ma < mb);
      r.lt = a_below;
      r.gt = ~a_below;
    end
    return r;
  endfunction

  always_comb rel = order_pair(a_sign, a_mag, a_nan, a_zero, b_sign, b_mag, b_nan, b_zero);
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate (
  input  logic [3:0]          cond,
  input  fcmp_pkg::relation_t rel,
  input  logic                a_nan,
  input  logic                a_snan,
  input  logic                b_nan,
  input  logic                b_snan,
  output logic                hit,
  output logic                invalid
);
  import fcmp_pkg::*;

  always_comb begin
    hit = (cond[SEL_UN] & rel.un) | (cond[SEL_EQ] & rel.eq) | (cond[SEL_LT] & rel.lt);
    invalid = cond[SEL_SIGNALLING] ? (a_nan | b_nan) : (a_snan | b_snan);
  end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit #(
  parameter int EXP_W  = fcmp_pkg::SP_EXP_W,
  parameter int FRAC_W = fcmp_pkg::SP_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cond,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic              result,
  output logic              invalid,
  output logic              done
);
  import fcmp_pkg::*;

  logic [1:0]             op_sign, op_nan, op_snan, op_zero;
  logic [1:0][MAG_W-1:0]  op_mag;
  logic [1:0][WORD_W-1:0] op_word;
  relation_t              rel;
  logic                   hit_now;
  logic                   inv_now;

  assign op_word[0] = opa;
  assign op_word[1] = opb;

  for (genvar i = 0; i < 2; i++) begin : g_side
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word    (op_word[i]),
      .sign    (op_sign[i]),
      .mag     (op_mag[i]),
      .is_nan  (op_nan[i]),
      .is_snan (op_snan[i]),
      .is_zero (op_zero[i])
    );
  end

  fcmp_relate #(.MAG_W(MAG_W)) u_rel (
    .a_sign (op_sign[0]), .a_mag (op_mag[0]), .a_nan (op_nan[0]), .a_zero (op_zero[0]),
    .b_sign (op_sign[1]), .b_mag (op_mag[1]), .b_nan (op_nan[1]), .b_zero (op_zero[1]),
    .rel    (rel)
  );

  fcmp_predicate u_pred (
    .cond    (cond),
    .rel     (rel),
    .a_nan   (op_nan[0]),
    .a_snan  (op_snan[0]),
    .b_nan   (op_nan[1]),
    .b_snan  (op_snan[1]),
    .hit     (hit_now),
    .invalid (inv_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= 1'b0;
      invalid <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result  <= hit_now;
        invalid <= inv_now;
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);                                                        // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);                                                      // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(invalid)));                      // R11
  AST_MASK_NONE_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cond[2:0] == 3'b000) |=> !result);                            // R4
  AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($countones(rel) == 1));                                      // R6
  AST_SIGNED_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_zero[0] && op_zero[1]) |-> rel.eq);                        // R7
  AST_SIGNAL_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cond[3] && (op_nan[0] || op_nan[1])) |=> invalid);            // R9
  AST_QUIET_QNAN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cond[3] && !op_snan[0] && !op_snan[1]) |=> !invalid);        // R10
endmodule

// File: tb/fcmp_cond_unit_test.sv
module fcmp_cond_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cond = 4'd0;
  logic [31:0] opa = 32'd0;
  logic [31:0] opb = 32'd0;
  logic        result, invalid, done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  fcmp_cond_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cond(cond),
    .opa(opa), .opb(opb), .result(result), .invalid(invalid), .done(done)
  );

  localparam logic [31:0] POS_ZERO = 32'h0000_0000, NEG_ZERO = 32'h8000_0000;
  localparam logic [31:0] POS_INF  = 32'h7F80_0000, NEG_INF  = 32'hFF80_0000;
  localparam logic [31:0] QNAN     = 32'h7FC0_0000, SNAN     = 32'h7F80_0001;
  localparam logic [31:0] ONE      = 32'h3F80_0000, TWO      = 32'h4000_0000;
  localparam logic [31:0] M_ONE    = 32'hBF80_0000, M_TWO    = 32'hC000_0000;
  localparam logic [31:0] MAX_FIN  = 32'h7F7F_FFFF;

  function automatic bit is_nan_f(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // ordering key: signed integer whose order matches the real value order
  function automatic longint order_key(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic bit ref_result(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    bit u, e, l;
    u = is_nan_f(a) || is_nan_f(b);
    e = !u && (order_key(a) == order_key(b));
    l = !u && (order_key(a) < order_key(b));
    case (c & 4'h7)
      4'd0: return 1'b0;
      4'd1: return u;
      4'd2: return e;
      4'd3: return u || e;
      4'd4: return l;
      4'd5: return u || l;
      4'd6: return l || e;
      default: return u || l || e;
    endcase
  endfunction

  function automatic bit ref_invalid(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    bit sa, sb;
    sa = is_nan_f(a) && !a[22];
    sb = is_nan_f(b) && !b[22];
    if (c >= 4'd8) return is_nan_f(a) || is_nan_f(b);
    return sa || sb;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (cond=%h a=%h b=%h)", tag, act, exp, cond, opa, opb);
    end
  endtask

  task automatic compare(input string tag, input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cond = c; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " done R2"}, done, 1'b1);
    check({tag, " result R3"}, result, ref_result(c, a, b));
    check({tag, " invalid"}, invalid, ref_invalid(c, a, b));
  endtask

  // idle with disturbed inputs; outputs must hold (R11, R2)
  task automatic idle_hold(input string tag);
    logic r0, i0;
    r0 = result; i0 = invalid;
    @(negedge clk);
    cond = 4'($urandom); opa = SNAN; opb = QNAN;
    @(negedge clk);
    check({tag, " R2 no done"}, done, 1'b0);
    check({tag, " R11 result hold"}, result, r0);
    check({tag, " R11 invalid hold"}, invalid, i0);
  endtask

  function automatic logic [31:0] pick_operand(input logic [31:0] other);
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: return r;
      1: return {r[31], 31'd0};
      2: return {r[31], 8'hFF, 23'd0};
      3: return {r[31], 8'hFF, 1'b1, r[21:0]};
      4: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      5: return {r[31], 8'h00, r[22:0]};
      6: return other;
      default: return {other[31:23], other[22:4], r[3:0]};
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_F00D));
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 1'b0);
    check("R1 reset invalid", invalid, 1'b0);
    check("R1 reset done", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset done", done, 1'b0);
    check("R1 post-reset result", result, 1'b0);

    compare("R7 +0==-0", 4'd2, POS_ZERO, NEG_ZERO);
    compare("R7 -0==+0", 4'd2, NEG_ZERO, POS_ZERO);
    compare("R7 -0 not less", 4'd4, NEG_ZERO, POS_ZERO);
    compare("R4 mask none equal", 4'd0, ONE, ONE);
    idle_hold("after false");
    compare("R4 R9 sig false qnan", 4'd8, QNAN, ONE);
    compare("R6 R10 quiet unord qnan", 4'd1, ONE, QNAN);
    compare("R10 quiet snan", 4'd2, SNAN, ONE);
    compare("R10 quiet snan false", 4'd0, ONE, SNAN);
    compare("R9 sig eq qnan", 4'd10, QNAN, QNAN);
    idle_hold("after nan");
    compare("R8 subnormal lt", 4'd4, 32'h0000_0001, 32'h0000_0002);
    compare("R8 neg lt", 4'd4, M_TWO, M_ONE);
    compare("R8 neg not lt", 4'd4, M_ONE, M_TWO);
    compare("R8 sign lt", 4'd6, M_ONE, ONE);
    compare("R12 -inf lt max", 4'd4, NEG_INF, MAX_FIN);
    compare("R12 max lt +inf", 4'd4, MAX_FIN, POS_INF);
    compare("R12 inf eq", 4'd2, POS_INF, POS_INF);
    compare("R5 quiet le", 4'd6, ONE, TWO);
    compare("R5 sig le", 4'd14, ONE, TWO);
    compare("R5 sig ule unord", 4'd15, SNAN, TWO);
    idle_hold("after directed");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] a, b;
      logic [3:0] c;
      a = pick_operand(32'h3FC0_0000);
      b = pick_operand(a);
      c = 4'($urandom);
      compare("R4 R6 R8 R9 R10 random", c, a, b);
      compare("R5 random pair", c ^ 4'h8, a, b);
      if (k % 50 == 0) idle_hold("random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule